// File: doc/BRIEF.md
# Serial Interrupt Peripheral Agent

This block is the device end of the shared, active-low serial interrupt wire. It watches the open-drain line and follows each frame: a start pulse, then seventeen three-clock data slots, then a stop pulse. In the sample clock of slot n it pulls the line low when local request n is pending. The top slot (index 16) carries the I/O channel check request. The wire itself, its pull-up and any tri-state buffer sit outside. The block gives a drive enable and a drive value and takes back the resolved level of the line.

The agent has two modes, and the width of each stop pulse selects the one that applies next. In continuous mode only the host opens frames, and the agent answers every frame for as long as a request stays pending. In quiet mode the agent may open a frame itself. It does so when a request appears that has not yet been signalled and no frame is under way. It pulls the line low for a single clock, then lets go and leaves the host to extend the start pulse. A polarity input decides whether a request bit is taken as is or inverted before it decides the slot drive.

Top module: `serirq_agent`

## Requirements
- R1: While reset is held and right after it, the agent does not drive the line (`serirq_oe` = 0) and reports continuous mode (`quiet_mode` = 0).
- R2: A low period of 4 or more clocks followed by a high level is a start frame. After the first high clock, slots 0..16 follow back to back. Slot n is driven low in its first clock when request bit n is pending (bit 12 drives slot 12, bit 16 drives the channel check slot).
- R3: Each slot is 3 clocks long. A driven slot is low in clock 1 (sample), actively high in clock 2 (recovery) and released in clock 3 (turnaround). A slot whose request is not pending is never driven.
- R4: A low period shorter than 4 clocks is not a start frame. The agent drives nothing after it and still tracks the next valid frame.
- R5: After slot 16, a stop pulse 2 clocks wide selects quiet mode (`quiet_mode` = 1) and one 3 clocks wide selects continuous mode. Any other width leaves the mode unchanged.
- R6: In continuous mode the agent never opens a frame. A request held high is signalled in every frame the host opens.
- R7: In quiet mode, on an idle line, a request not yet signalled makes the agent drive the line low for exactly one clock. This happens in the clock after the request is first seen, and the frame the host completes then carries that request.
- R8: In quiet mode, a request that has already been signalled and is still held opens no new frame. Once it drops and rises again, it opens one.
- R9: The agent never opens a frame while one is in progress. A request that arrives after its slot has passed is left out of that frame, and the agent opens a new frame once the stop pulse has ended.
- R10: With `cfg_invert` = 1, a slot is driven when its request bit is 0. With `cfg_invert` = 0 (default), it is driven when the bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| serirq_in | input | 1 | Resolved level of the shared line |
| irq_req | input | 17 | Local requests, bit n for slot n, bit 16 the channel check slot |
| cfg_invert | input | 1 | 1: invert each request before slot drive |
| serirq_oe | output | 1 | Drive enable for the line |
| serirq_dout | output | 1 | Value driven when enabled |
| quiet_mode | output | 1 | 1 when quiet mode is selected |

## Verification
The hardest case to reach is a request that arrives in quiet mode while a frame is already running, after its own slot has passed. The agent must not open a second frame, and it must still open one once the stop pulse is over. The bench reaches this by having its host model raise the new request during slot 10 of a frame it is driving. It then checks that the frame carried no stray low, and it watches the idle line after the stop pulse for the agent's one-clock start. The rearm path is reached in a similar way: the bench holds a request that has already been signalled, drops it, then raises it again.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QSTART,
    ST_START,
    ST_SLOT,
    ST_STOP
  } frame_st_t;

  typedef enum logic [1:0] {
    MD_KEEP,
    MD_QUIET,
    MD_CONT
  } mode_sel_t;

  localparam logic [1:0] PH_SAMPLE = 2'd0;
  localparam logic [1:0] PH_RECOV  = 2'd1;
  localparam logic [1:0] PH_TURN   = 2'd2;

  // request as seen by the slot logic after polarity selection
  function automatic logic slot_pending(input logic req, input logic inv);
    return req ^ inv;
  endfunction

  // mode picked by the width of a stop pulse
  function automatic mode_sel_t stop_decode(input int width, input int quiet_w, input int cont_w);
    if (width == quiet_w) return MD_QUIET;
    if (width == cont_w)  return MD_CONT;
    return MD_KEEP;
  endfunction

endpackage

// File: rtl/serirq_frame_tracker.sv
module serirq_frame_tracker
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 17,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int CNT_W      = 4,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              qs_want,
  output frame_st_t         st,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [1:0]        phase,
  output logic              quiet_mode
);

  localparam logic [CNT_W-1:0]  START_MIN_C = CNT_W'(START_MIN);
  localparam logic [SLOT_W-1:0] LAST_SLOT   = SLOT_W'(NUM_SLOTS - 1);

  logic [CNT_W-1:0] wcnt;

  // named events for checking
  logic start_end, short_pulse, stop_end, slot_wrap;
  assign start_end   = (st == ST_START) && line_in;
  assign short_pulse = start_end && (wcnt < START_MIN_C);
  assign stop_end    = (st == ST_STOP) && line_in && (wcnt != '0);
  assign slot_wrap   = (st == ST_SLOT) && (phase == PH_TURN) && (slot_idx == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      slot_idx   <= '0;
      phase      <= PH_SAMPLE;
      wcnt       <= '0;
      quiet_mode <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (!line_in) begin
            st   <= ST_START;
            wcnt <= CNT_W'(1);
          end else if (qs_want) begin
            st <= ST_QSTART;
          end
        end
        ST_QSTART: begin
          st   <= ST_START;
          wcnt <= CNT_W'(1);
        end
        ST_START: begin
          if (!line_in) begin
            wcnt <= (wcnt == '1) ? wcnt : wcnt + 1'b1;
          end else if (short_pulse) begin
            st <= ST_IDLE;
          end else begin
            st       <= ST_SLOT;
            slot_idx <= '0;
            phase    <= PH_SAMPLE;
          end
        end
        ST_SLOT: begin
          if (phase == PH_TURN) begin
            phase <= PH_SAMPLE;
            if (slot_wrap) begin
              st   <= ST_STOP;
              wcnt <= '0;
            end else begin
              slot_idx <= slot_idx + 1'b1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_STOP: begin
          if (!line_in) begin
            wcnt <= (wcnt == '1) ? wcnt : wcnt + 1'b1;
          end else if (stop_end) begin
            st <= ST_IDLE;
            unique case (stop_decode(int'(wcnt), STOP_QUIET, STOP_CONT))
              MD_QUIET: quiet_mode <= 1'b1;
              MD_CONT:  quiet_mode <= 1'b0;
              default:  quiet_mode <= quiet_mode;
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_qstart_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_QSTART) |=> (st == ST_START));

  p_qstart_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_QSTART) |-> ($past(st) == ST_IDLE));

  p_qstart_quiet_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_QSTART) |-> quiet_mode);

  p_mode_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quiet_mode) |-> ($past(st) == ST_STOP));

  p_short_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    short_pulse |=> (st == ST_IDLE));

endmodule

// File: rtl/serirq_slot_driver.sv
module serirq_slot_driver
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS = 17,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_in,
  input  logic [NUM_SLOTS-1:0] irq_req,
  input  logic                 cfg_invert,
  input  frame_st_t            st,
  input  logic [SLOT_W-1:0]    slot_idx,
  input  logic [1:0]           phase,
  input  logic                 quiet_mode,
  output logic                 qs_want,
  output logic                 oe,
  output logic                 dout
);

  logic [NUM_SLOTS-1:0] pend;
  logic [NUM_SLOTS-1:0] served;
  logic                 drove_sample;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_pol
    assign pend[g] = slot_pending(irq_req[g], cfg_invert);
  end

  logic in_sample, in_recov, in_turn, sample_hit;
  assign in_sample  = (st == ST_SLOT) && (phase == PH_SAMPLE);
  assign in_recov   = (st == ST_SLOT) && (phase == PH_RECOV);
  assign in_turn    = (st == ST_SLOT) && (phase == PH_TURN);
  assign sample_hit = in_sample && pend[slot_idx];

  assign qs_want = quiet_mode && (st == ST_IDLE) && line_in && (|(pend & ~served));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served       <= '0;
      drove_sample <= 1'b0;
    end else begin
      served       <= (served & pend) | (sample_hit ? (NUM_SLOTS'(1) << slot_idx) : '0);
      drove_sample <= sample_hit;
    end
  end

  always_comb begin
    oe   = 1'b0;
    dout = 1'b1;
    if (st == ST_QSTART) begin
      oe   = 1'b1;
      dout = 1'b0;
    end else if (sample_hit) begin
      oe   = 1'b1;
      dout = 1'b0;
    end else if (in_recov && drove_sample) begin
      oe   = 1'b1;
      dout = 1'b1;
    end
  end

  p_turn_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_turn |-> !oe);

  p_recovery_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sample && oe) |=> (oe && dout));

  p_low_only_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !dout) |-> (in_sample || (st == ST_QSTART)));

endmodule

// File: rtl/serirq_agent.sv
module serirq_agent
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 17,
  parameter int START_MIN  = 4,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  parameter int CNT_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 serirq_in,
  input  logic [NUM_SLOTS-1:0] irq_req,
  input  logic                 cfg_invert,
  output logic                 serirq_oe,
  output logic                 serirq_dout,
  output logic                 quiet_mode
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  frame_st_t         st;
  logic [SLOT_W-1:0] slot_idx;
  logic [1:0]        phase;
  logic              qs_want;

  serirq_frame_tracker #(
    .NUM_SLOTS(NUM_SLOTS), .START_MIN(START_MIN),
    .STOP_QUIET(STOP_QUIET), .STOP_CONT(STOP_CONT), .CNT_W(CNT_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .line_in(serirq_in), .qs_want(qs_want),
    .st(st), .slot_idx(slot_idx), .phase(phase), .quiet_mode(quiet_mode)
  );

  serirq_slot_driver #(.NUM_SLOTS(NUM_SLOTS)) u_drive (
    .clk(clk), .rst_n(rst_n), .line_in(serirq_in), .irq_req(irq_req),
    .cfg_invert(cfg_invert), .st(st), .slot_idx(slot_idx), .phase(phase),
    .quiet_mode(quiet_mode), .qs_want(qs_want), .oe(serirq_oe), .dout(serirq_dout)
  );

  p_idle_no_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) || (st == ST_START) || (st == ST_STOP)) |-> !serirq_oe);

endmodule

// File: tb/serirq_agent_bench.sv
`timescale 1ns/1ps
module serirq_agent_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_low = 1'b0;
  logic [16:0] irq_req = '0;
  logic        cfg_invert = 1'b0;
  logic        oe, dout, quiet;
  logic        line;

  assign line = !(host_low || (oe && !dout));

  always #4 clk = ~clk;

  serirq_agent u_serirq_agent (
    .clk(clk), .rst_n(rst_n), .serirq_in(line), .irq_req(irq_req),
    .cfg_invert(cfg_invert), .serirq_oe(oe), .serirq_dout(dout), .quiet_mode(quiet)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [16:0] obs_mask;
  int          obs_bad;

  // host drives a whole frame; starts and ends on a negedge
  task automatic host_frame(input int slen, input int plen, input bit mid_en, input logic [16:0] mid_bits);
    obs_mask = '0;
    obs_bad  = 0;
    host_low = 1'b1;
    repeat (slen) @(negedge clk);
    host_low = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 17; s++) begin
      for (int ph = 0; ph < 3; ph++) begin
        if (ph == 0) begin
          obs_mask[s] = !line;
          if (mid_en && s == 10) irq_req = irq_req | mid_bits;
        end else if (ph == 1) begin
          if (obs_mask[s] ? !(oe && dout) : oe) obs_bad++;
        end else begin
          if (oe) obs_bad++;
        end
        @(negedge clk);
      end
    end
    host_low = 1'b1;
    repeat (plen) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic wait_self_start(output bit seen);
    seen = 0;
    for (int i = 0; i < 4 && !seen; i++) begin
      @(negedge clk);
      if (!line && !host_low) seen = 1;
    end
  endtask

  typedef struct packed {
    logic [16:0] req;
    logic        inv;
    logic [3:0]  slen;
    logic [3:0]  plen;
    logic [16:0] exp_mask;
    logic        exp_quiet;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{17'h01000, 1'b0, 4'd4, 4'd3, 17'h01000, 1'b0},  // R2 IRQ12
    '{17'h10001, 1'b0, 4'd8, 4'd3, 17'h10001, 1'b0},  // R2 slot 0 and channel check
    '{17'h0AAAA, 1'b0, 4'd6, 4'd5, 17'h0AAAA, 1'b0},  // R5 width 5 keeps mode
    '{17'h1FFFE, 1'b1, 4'd5, 4'd3, 17'h00001, 1'b0},  // R10 inverted
    '{17'h00000, 1'b0, 4'd4, 4'd2, 17'h00000, 1'b1},  // R5 to quiet
    '{17'h00000, 1'b0, 4'd7, 4'd4, 17'h00000, 1'b1},  // R5 width 4 keeps
    '{17'h00000, 1'b0, 4'd4, 4'd3, 17'h00000, 1'b0}   // R5 back to continuous
  };

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit seen;
    int bad;
    repeat (3) @(negedge clk);
    check(!oe, "R1 drive in reset", oe, 0);
    check(!quiet, "R1 mode in reset", quiet, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!oe && !quiet, "R1 after reset", {oe, quiet}, 0);

    // table walk: R2 R3 R5 R10
    for (int v = 0; v < 7; v++) begin
      irq_req    = VEC[v].req;
      cfg_invert = VEC[v].inv;
      @(negedge clk);
      host_frame(int'(VEC[v].slen), int'(VEC[v].plen), 1'b0, '0);
      @(negedge clk);
      check(obs_mask == VEC[v].exp_mask, "R2/R10 slot mask", obs_mask, VEC[v].exp_mask);
      check(obs_bad == 0, "R3 recovery/turnaround", obs_bad, 0);
      check(quiet == VEC[v].exp_quiet, "R5 mode", quiet, VEC[v].exp_quiet);
    end
    cfg_invert = 1'b0;

    // R4 short low pulse
    irq_req = 17'h00002;
    host_low = 1'b1;
    repeat (3) @(negedge clk);
    host_low = 1'b0;
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (oe) bad++;
    end
    check(bad == 0, "R4 short pulse drive", bad, 0);
    host_frame(4, 3, 1'b0, '0);
    @(negedge clk);
    check(obs_mask == 17'h00002, "R4 next frame", obs_mask, 17'h00002);

    // enter quiet mode
    irq_req = '0;
    host_frame(5, 2, 1'b0, '0);
    @(negedge clk);
    check(quiet, "R5 stop 2 quiet", quiet, 1);

    // R7 self start one clock after request
    irq_req = 17'h00080;
    @(negedge clk);
    check(oe && !dout && !line, "R7 self start low", {oe, dout}, 2);
    host_frame(6, 2, 1'b0, '0);
    check(obs_mask == 17'h00080, "R7 frame mask", obs_mask, 17'h00080);
    @(negedge clk);

    // R8 held request opens nothing
    bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (!line) bad++;
    end
    check(bad == 0, "R8 held no restart", bad, 0);
    irq_req = '0;
    @(negedge clk);
    irq_req = 17'h00080;
    wait_self_start(seen);
    check(seen, "R8 rearm start", seen, 1);

    // R9 request raised mid frame after its slot
    host_frame(4, 2, 1'b1, 17'h00008);
    check(obs_mask == 17'h00080, "R9 mid frame mask", obs_mask, 17'h00080);
    check(obs_bad == 0, "R9 no stray drive", obs_bad, 0);
    @(negedge clk);
    wait_self_start(seen);
    check(seen, "R9 start after stop", seen, 1);
    host_frame(4, 3, 1'b0, '0);
    check(obs_mask == 17'h00088, "R9 served frame", obs_mask, 17'h00088);
    @(negedge clk);
    check(!quiet, "R5 stop 3 continuous", quiet, 0);

    // R6 continuous: no self start, held request repeats
    bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (!line) bad++;
    end
    check(bad == 0, "R6 no self start", bad, 0);
    host_frame(4, 3, 1'b0, '0);
    check(obs_mask == 17'h00088, "R6 repeat mask", obs_mask, 17'h00088);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule